// File: doc/BRIEF.md
# Retrace-Synchronised Hardware Cursor Overlay

This block mixes a 32×32 pointer image into a display pipeline's pixel stream. Each clock it takes the raster coordinate being produced, the 24-bit pixel colour coming from the frame source and a display-active flag. It returns a 24-bit pixel one clock later. When the raster falls inside the cursor window, the stored cursor word for that spot decides the result: leave the pixel alone, replace it with an opaque colour, or invert it.

The cursor image is held in an internal RAM of 16-bit words. Software fills the RAM through a small write-only register port. The same port sets the cursor's on/off state and its screen position. These two settings land first in shadow registers. They move into the live copies only on the rising edge of the vertical retrace signal, so a pointer never tears mid-frame. Image words take effect at once.

Top module: `hwcur_overlay`

## Requirements
- R1: While reset is asserted, `pixOut` is 0. After reset the cursor is off, so pixels pass through until software enables it and a retrace occurs.
- R2: The output has one clock of latency. With the live cursor off, `pixOut` equals the `pixIn` presented one clock earlier.
- R3: A cursor word of 0x0000 is transparent, and the underlying pixel passes through.
- R4: A cursor word with bit 15 set is an opaque colour. Red is bits 14:10, green 9:5 and blue 4:0. Each 5-bit channel c becomes {c, c[4:2]}, and the output is {R8,G8,B8}. So 0xFFFF gives 0xFFFFFF and 0x8000 gives 0x000000.
- R5: A non-zero cursor word with bit 15 clear (for example 0x7FFF) inverts the pixel: the output is the bitwise complement of the 24-bit `pixIn`.
- R6: With live position (cx, cy), raster (cx+col, cy+row) for col and row in 0..31 uses image word row*32+col. Rasters at cx-1, cx+32, cy-1 or cy+32 pass through.
- R7: Register address 1 holds the position: x in data bits 11:0 and y in bits 27:16. A write becomes live only at the next rising edge of `vRetrace`. Holding `vRetrace` high does not apply later writes until the next rising edge.
- R8: Register address 0, bit 0, is the cursor enable. It is shadowed and applied at the same retrace edge as the position, even when no position write occurred.
- R9: When `activeDisp` is low, the pixel passes through whatever the cursor state.
- R10: Register address 2 writes the image. The word index (row*32+col) is in data bits 25:16 and the pixel word in bits 15:0. The write is visible to rasters from the next clock on. Address 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select (0 enable, 1 position, 2 image) |
| regData | input | 32 | Register write data |
| vRetrace | input | 1 | Vertical retrace flag; rising edge applies the shadows |
| activeDisp | input | 1 | High in the visible display area |
| rasterX | input | 12 | Current raster column |
| rasterY | input | 12 | Current raster line |
| pixIn | input | 24 | Underlying pixel, RGB888 |
| pixOut | output | 24 | Mixed pixel, one clock after the inputs |

## Verification
The assertions check, on every cycle, the following:
- the reset value;
- pass-through whenever the live cursor is off or the display is blanked;
- the copy of all shadow settings into the live registers on a retrace rising edge;
- that the live settings never change on any other cycle.

Only the bench's scenarios can show the rest:
- the colour decoding of transparent, opaque and invert words;
- the exact window edges and row-major image addressing;
- the deferral of position and enable writes across several retrace patterns.

The random sweep compares each mixed pixel against a model of the image and the shadow and live registers.

// File: rtl/hwcur_pkg.sv
package hwcur_pkg;
  localparam int WORD_W = 16;
  localparam int PIX_W  = 24;
  localparam int CH_W   = 5;

  typedef enum logic [1:0] {
    REG_ENABLE = 2'd0,
    REG_POS    = 2'd1,
    REG_IMAGE  = 2'd2,
    REG_NONE   = 2'd3
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic imgWr;
    logic posLatch;
  } ctlStrobe_t;
endpackage

// File: rtl/hwcur_ctrl.sv
module hwcur_ctrl
  import hwcur_pkg::*;
#(
  parameter int COORD_W = 12,
  parameter int IDX_W   = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [1:0]         regAddr,
  input  logic [31:0]        regData,
  input  logic               vRetrace,
  output ctlStrobe_t         strb,
  output logic               shadowEn,
  output logic [COORD_W-1:0] shadowX,
  output logic [COORD_W-1:0] shadowY,
  output logic [IDX_W-1:0]   imgIdx,
  output logic [WORD_W-1:0]  imgWord
);
  localparam int Y_LSB = 16;

  regSel_e sel;
  logic    retPrev;

  assign sel = regSel_e'(regAddr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      retPrev  <= 1'b0;
      shadowEn <= 1'b0;
      shadowX  <= '0;
      shadowY  <= '0;
    end else begin
      retPrev <= vRetrace;
      if (regWrEn && sel == REG_ENABLE) shadowEn <= regData[0];
      if (regWrEn && sel == REG_POS) begin
        shadowX <= regData[COORD_W-1:0];
        shadowY <= regData[Y_LSB +: COORD_W];
      end
    end
  end

  assign strb.imgWr    = regWrEn && (sel == REG_IMAGE);
  assign strb.posLatch = vRetrace && !retPrev;
  assign imgIdx        = regData[Y_LSB +: IDX_W];
  assign imgWord       = regData[WORD_W-1:0];
endmodule

// File: rtl/hwcur_datapath.sv
module hwcur_datapath
  import hwcur_pkg::*;
#(
  parameter int CUR_DIM = 32,
  parameter int COORD_W = 12,
  parameter int IDX_W   = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strb,
  input  logic               shadowEn,
  input  logic [COORD_W-1:0] shadowX,
  input  logic [COORD_W-1:0] shadowY,
  input  logic [IDX_W-1:0]   imgIdx,
  input  logic [WORD_W-1:0]  imgWord,
  input  logic [COORD_W-1:0] rasterX,
  input  logic [COORD_W-1:0] rasterY,
  input  logic               activeDisp,
  input  logic [PIX_W-1:0]   pixIn,
  output logic [PIX_W-1:0]   pixOut,
  output logic               actEn,
  output logic [COORD_W-1:0] actX,
  output logic [COORD_W-1:0] actY
);
  localparam int CELLS  = CUR_DIM * CUR_DIM;
  localparam int SIDE_W = $clog2(CUR_DIM);
  localparam logic [COORD_W-1:0] DIM_C = COORD_W'(CUR_DIM);

  logic [WORD_W-1:0]  imgRam [CELLS];
  logic [COORD_W-1:0] dx, dy;
  logic               inWin, useCur;
  logic [IDX_W-1:0]   rdIdx;
  logic [WORD_W-1:0]  curWord;
  logic [PIX_W-1:0]   opaqueRgb, mixed;

  always_ff @(posedge clk) begin
    if (strb.imgWr) imgRam[imgIdx] <= imgWord;
  end

  // live copies, loaded only on a retrace rising edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actEn <= 1'b0;
      actX  <= '0;
      actY  <= '0;
    end else if (strb.posLatch) begin
      actEn <= shadowEn;
      actX  <= shadowX;
      actY  <= shadowY;
    end
  end

  assign dx     = rasterX - actX;
  assign dy     = rasterY - actY;
  assign inWin  = (rasterX >= actX) && (dx < DIM_C) &&
                  (rasterY >= actY) && (dy < DIM_C);
  assign rdIdx  = {dy[SIDE_W-1:0], dx[SIDE_W-1:0]};
  assign curWord = imgRam[rdIdx];
  assign useCur = actEn && activeDisp && inWin && (curWord != '0);

  // 5-bit to 8-bit channel widening by top-bit replication
  for (genvar c = 0; c < 3; c++) begin : g_chan
    assign opaqueRgb[c*8 +: 8] = {curWord[c*CH_W +: CH_W], curWord[c*CH_W + 2 +: 3]};
  end

  always_comb begin
    mixed = pixIn;
    if (useCur) begin
      if (curWord[WORD_W-1]) mixed = opaqueRgb;
      else                   mixed = ~pixIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pixOut <= '0;
    else       pixOut <= mixed;
  end
endmodule

// File: rtl/hwcur_overlay.sv
module hwcur_overlay
  import hwcur_pkg::*;
#(
  parameter int CUR_DIM = 32,
  parameter int COORD_W = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [1:0]         regAddr,
  input  logic [31:0]        regData,
  input  logic               vRetrace,
  input  logic               activeDisp,
  input  logic [COORD_W-1:0] rasterX,
  input  logic [COORD_W-1:0] rasterY,
  input  logic [23:0]        pixIn,
  output logic [23:0]        pixOut
);
  localparam int IDX_W = 2 * $clog2(CUR_DIM);

  ctlStrobe_t         strb;
  logic               shadowEn, actEn;
  logic [COORD_W-1:0] shadowX, shadowY, actX, actY;
  logic [IDX_W-1:0]   imgIdx;
  logic [WORD_W-1:0]  imgWord;

  hwcur_ctrl #(.COORD_W(COORD_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regData(regData), .vRetrace(vRetrace), .strb(strb),
    .shadowEn(shadowEn), .shadowX(shadowX), .shadowY(shadowY),
    .imgIdx(imgIdx), .imgWord(imgWord)
  );

  hwcur_datapath #(.CUR_DIM(CUR_DIM), .COORD_W(COORD_W), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .shadowEn(shadowEn),
    .shadowX(shadowX), .shadowY(shadowY), .imgIdx(imgIdx), .imgWord(imgWord),
    .rasterX(rasterX), .rasterY(rasterY), .activeDisp(activeDisp),
    .pixIn(pixIn), .pixOut(pixOut), .actEn(actEn), .actX(actX), .actY(actY)
  );
endmodule

// File: rtl/hwcur_checker.sv
module hwcur_checker #(
  parameter int COORD_W = 12
) (
  input logic               clk,
  input logic               rstN,
  input logic               vRetrace,
  input logic               activeDisp,
  input logic [23:0]        pixIn,
  input logic [23:0]        pixOut,
  input logic               actEn,
  input logic [COORD_W-1:0] actX,
  input logic [COORD_W-1:0] actY,
  input logic               shadowEn,
  input logic [COORD_W-1:0] shadowX,
  input logic [COORD_W-1:0] shadowY
);
  // R1: held reset keeps the output and live enable cleared
  a_r1_reset_state: assert property (@(posedge clk)
    ($past(!rstN) && !rstN) |-> (pixOut == '0 && !actEn));

  // R2: live cursor off means a one-clock pass-through
  a_r2_off_passthrough: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(actEn)) |-> pixOut == $past(pixIn));

  // R9: blanked area always passes through
  a_r9_blank_passthrough: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(activeDisp)) |-> pixOut == $past(pixIn));

  // R7 / R8: a retrace rising edge copies every shadow setting
  a_r7_latch_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && vRetrace && !$past(vRetrace)) |=>
      (actX == $past(shadowX) && actY == $past(shadowY) && actEn == $past(shadowEn)));

  // R8: live settings hold on every other cycle
  a_r8_hold_between: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !(vRetrace && !$past(vRetrace))) |=>
      ($stable(actX) && $stable(actY) && $stable(actEn)));
endmodule

bind hwcur_overlay hwcur_checker #(.COORD_W(COORD_W)) u_chk (
  .clk(clk), .rstN(rstN), .vRetrace(vRetrace), .activeDisp(activeDisp),
  .pixIn(pixIn), .pixOut(pixOut), .actEn(actEn), .actX(actX), .actY(actY),
  .shadowEn(shadowEn), .shadowX(shadowX), .shadowY(shadowY)
);

// File: tb/tb_hwcur_overlay.sv
module tb_hwcur_overlay;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [31:0] regData = '0;
  logic        vRetrace = 1'b0;
  logic        activeDisp = 1'b0;
  logic [11:0] rasterX = '0;
  logic [11:0] rasterY = '0;
  logic [23:0] pixIn = '0;
  logic [23:0] pixOut;

  always #5 clk = ~clk;

  hwcur_overlay dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regData(regData), .vRetrace(vRetrace), .activeDisp(activeDisp),
    .rasterX(rasterX), .rasterY(rasterY), .pixIn(pixIn), .pixOut(pixOut)
  );

  int checks = 0;
  int fails  = 0;

  // bench model
  int img [1024];
  bit shEn = 0, acEn = 0, prevRet = 0;
  int shX = 0, shY = 0, acX = 0, acY = 0;

  task automatic check(input logic [23:0] got, input logic [23:0] exp, input string req);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [23:0] widen(input int w);
    logic [4:0] r, g, b;
    r = 5'((w >> 10) & 31);
    g = 5'((w >> 5) & 31);
    b = 5'(w & 31);
    return {r, r[4:2], g, g[4:2], b, b[4:2]};
  endfunction

  function automatic logic [23:0] predict(input int x, input int y, input bit act, input logic [23:0] pix);
    int w;
    if (!act || !acEn) return pix;
    if (x < acX || x >= acX + 32 || y < acY || y >= acY + 32) return pix;
    w = img[(y - acY) * 32 + (x - acX)];
    if (w == 0) return pix;
    if ((w & 32'h8000) != 0) return widen(w);
    return ~pix;
  endfunction

  // one clock: drive at negedge, compare at the following negedge
  task automatic cyc(input int x, input int y, input bit act, input bit ret,
                     input logic [23:0] pix, input bit wr, input logic [1:0] a,
                     input logic [31:0] d, input string req);
    logic [23:0] exp;
    rasterX = 12'(x); rasterY = 12'(y); activeDisp = act; vRetrace = ret;
    pixIn = pix; regWrEn = wr; regAddr = a; regData = d;
    exp = predict(x, y, act, pix);
    @(posedge clk);
    if (ret && !prevRet) begin acEn = shEn; acX = shX; acY = shY; end
    prevRet = ret;
    if (wr) begin
      case (a)
        2'd0: shEn = d[0];
        2'd1: begin shX = int'(d[11:0]); shY = int'(d[27:16]); end
        2'd2: img[int'(d[25:16])] = int'(d[15:0]);
        default: ;
      endcase
    end
    @(negedge clk);
    check(pixOut, exp, req);
  endtask

  task automatic idleWr(input logic [1:0] a, input logic [31:0] d, input bit ret, input string req);
    cyc(0, 0, 1'b1, ret, 24'h123456, 1'b1, a, d, req);
  endtask

  function automatic int rndWord();
    int k = int'($urandom % 4);
    int v = int'($urandom & 32'h7fff);
    if (k == 0) return 0;
    if (k == 1) return 32'h8000 | v;
    if (k == 2) return v | 1;
    return 32'h7fff;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int seedVal;
    seedVal = int'($urandom(32'd2024));
    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      check(pixOut, 24'h0, "R1 reset");
    end
    rstN = 1'b1;
    // R1/R2: fresh cursor is off, pass-through, one-clock latency
    cyc(10, 10, 1'b1, 1'b0, 24'habcdef, 1'b0, 2'd0, 0, "R1 off after reset");
    cyc(11, 10, 1'b1, 1'b0, 24'h00ff11, 1'b0, 2'd0, 0, "R2 latency");

    // R10: fill image with random words
    for (int i = 0; i < 1024; i++)
      idleWr(2'd2, (32'(i) << 16) | 32'(rndWord()), 1'b0, "R2 fill");
    idleWr(2'd2, (32'd0 << 16) | 32'h0000, 1'b0, "R10");
    idleWr(2'd2, (32'd1 << 16) | 32'hFFFF, 1'b0, "R10");
    idleWr(2'd2, (32'd2 << 16) | 32'h8000, 1'b0, "R10");
    idleWr(2'd2, (32'd3 << 16) | 32'h7FFF, 1'b0, "R10");
    idleWr(2'd2, (32'd4 << 16) | 32'h83E0, 1'b0, "R10");
    idleWr(2'd2, (32'd31 << 16) | 32'h0001, 1'b0, "R10");
    idleWr(2'd2, (32'd1023 << 16) | 32'hFC1F, 1'b0, "R10");
    idleWr(2'd3, (32'd1 << 16) | 32'h0000, 1'b0, "R10 addr3 ignored");

    // R7/R8: enable and position staged, not live yet
    idleWr(2'd0, 32'h1, 1'b0, "R8");
    idleWr(2'd1, (32'd50 << 16) | 32'd100, 1'b0, "R7");
    cyc(101, 50, 1'b1, 1'b0, 24'h112233, 1'b0, 2'd0, 0, "R7 pending");
    cyc(0, 0, 1'b1, 1'b1, 24'h0, 1'b0, 2'd0, 0, "R7 retrace");
    cyc(0, 0, 1'b1, 1'b0, 24'h0, 1'b0, 2'd0, 0, "R7 retrace end");

    // R3/R4/R5/R6 directed
    cyc(100, 50, 1'b1, 1'b0, 24'h445566, 1'b0, 2'd0, 0, "R3 transparent");
    cyc(101, 50, 1'b1, 1'b0, 24'h445566, 1'b0, 2'd0, 0, "R4 white");
    cyc(102, 50, 1'b1, 1'b0, 24'h445566, 1'b0, 2'd0, 0, "R4 black");
    cyc(103, 50, 1'b1, 1'b0, 24'h445566, 1'b0, 2'd0, 0, "R5 invert");
    cyc(104, 50, 1'b1, 1'b0, 24'h445566, 1'b0, 2'd0, 0, "R4 green");
    cyc(131, 81, 1'b1, 1'b0, 24'h445566, 1'b0, 2'd0, 0, "R6 last cell");
    cyc(131, 50, 1'b1, 1'b0, 24'h0f0f0f, 1'b0, 2'd0, 0, "R6 end of row");
    cyc(99, 50, 1'b1, 1'b0, 24'h445566, 1'b0, 2'd0, 0, "R6 left edge");
    cyc(132, 50, 1'b1, 1'b0, 24'h445566, 1'b0, 2'd0, 0, "R6 right edge");
    cyc(100, 49, 1'b1, 1'b0, 24'h445566, 1'b0, 2'd0, 0, "R6 top edge");
    cyc(100, 82, 1'b1, 1'b0, 24'h445566, 1'b0, 2'd0, 0, "R6 bottom edge");
    cyc(101, 50, 1'b0, 1'b0, 24'h445566, 1'b0, 2'd0, 0, "R9 blanked");
    cyc(103, 50, 1'b0, 1'b0, 24'h445566, 1'b0, 2'd0, 0, "R9 blanked invert");

    // R10: a new word is visible the next clock
    idleWr(2'd2, (32'd5 << 16) | 32'hFFFF, 1'b0, "R10 write");
    cyc(105, 50, 1'b1, 1'b0, 24'h000000, 1'b0, 2'd0, 0, "R10 visible");

    // R7: deferral, and held retrace does not re-latch
    idleWr(2'd1, (32'd300 << 16) | 32'd200, 1'b0, "R7 stage");
    cyc(101, 50, 1'b1, 1'b0, 24'h777777, 1'b0, 2'd0, 0, "R7 old pos live");
    cyc(0, 0, 1'b1, 1'b1, 24'h0, 1'b0, 2'd0, 0, "R7 rise");
    idleWr(2'd1, (32'd400 << 16) | 32'd400, 1'b1, "R7 write while high");
    cyc(201, 300, 1'b1, 1'b1, 24'h777777, 1'b0, 2'd0, 0, "R7 new pos live");
    cyc(401, 400, 1'b1, 1'b1, 24'h777777, 1'b0, 2'd0, 0, "R7 no relatch");
    cyc(101, 50, 1'b1, 1'b0, 24'h777777, 1'b0, 2'd0, 0, "R7 old pos gone");
    cyc(0, 0, 1'b1, 1'b1, 24'h0, 1'b0, 2'd0, 0, "R7 second rise");
    cyc(401, 400, 1'b1, 1'b0, 24'h777777, 1'b0, 2'd0, 0, "R7 applied");

    // R8: disable alone, applied at retrace
    idleWr(2'd0, 32'h0, 1'b0, "R8 stage off");
    cyc(401, 400, 1'b1, 1'b0, 24'h777777, 1'b0, 2'd0, 0, "R8 still on");
    cyc(0, 0, 1'b1, 1'b1, 24'h0, 1'b0, 2'd0, 0, "R8 rise");
    cyc(401, 400, 1'b1, 1'b0, 24'h777777, 1'b0, 2'd0, 0, "R8 off live");
    idleWr(2'd0, 32'h1, 1'b0, "R8 stage on");
    cyc(0, 0, 1'b1, 1'b1, 24'h0, 1'b0, 2'd0, 0, "R8 rise on");

    // random sweep
    for (int n = 0; n < 4000; n++) begin
      bit wr = ($urandom % 10) == 0;
      logic [1:0] a = 2'($urandom % 4);
      logic [31:0] d;
      bit ret = ($urandom % 40) == 0;
      int x = acX - 3 + int'($urandom % 38);
      int y = acY - 3 + int'($urandom % 38);
      if (x < 0) x = 0;
      if (y < 0) y = 0;
      if (a == 2'd1) d = ((32'($urandom % 400)) << 16) | 32'($urandom % 600);
      else if (a == 2'd0) d = 32'(($urandom % 4) != 0);
      else d = (32'($urandom % 1024) << 16) | 32'(rndWord());
      cyc(x, y, ($urandom % 10) != 0, ret, 24'($urandom), wr, a, d, "R6 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule